// File: doc/BRIEF.md
# Dual I/O Read Command Responder

This block plays the device side of a serial flash read that moves address and data two bits per clock. While the active-low select `cs_n` is low, it samples `io_in[1:0]` on each rising edge of `sclk` and decodes an 8-bit instruction. It then collects a 24-bit address and a mode byte, one bit pair per clock. After that it returns bytes from a small built-in pattern memory, one bit pair per clock, and advances the address after each byte. The block is meant as a synthesizable target against which a host-side read controller can be verified.

The mode byte can arm a continuous state that lasts across select cycles. While that state is armed, the next select assertion skips the instruction and treats its first clocks as address. The memory holds `DEPTH` bytes, a power of two. Only the low `log2(DEPTH)` address bits pick a location, and the byte stored at location `a` is `(29*a + 0x47) mod 256`.

The controller moves through five states:
- `ST_CMD`: instruction capture.
- `ST_ADDR`: address capture.
- `ST_MODE`: mode capture.
- `ST_DATA`: output.
- `ST_IGNORE`: unsupported instruction.

The transitions are:
- Select high: go to `ST_ADDR` when continuous is armed, otherwise to `ST_CMD`.
- `ST_CMD` to `ST_ADDR` after the 8th clock when the instruction is 0xBB. Any other value goes to `ST_IGNORE`.
- `ST_ADDR` to `ST_MODE` after 12 clocks.
- `ST_MODE` to `ST_DATA` after 4 clocks.
- `ST_DATA` and `ST_IGNORE` hold until select rises.

Top module: `dual_read_responder`

## Requirements
- R1: While `rst_n` is low and after its release, `io_oe` is 2'b00, continuous state is cleared, and the next select assertion begins with instruction capture.
- R2: In normal state, the first 8 rising clocks with select low capture an instruction from `io_in[0]`, MSB first. The value 0xBB starts a dual read.
- R3: The address is taken over the next 12 rising clocks, one pair per clock, MSB pair first. `io_in[1]` carries the odd bit and `io_in[0]` the even bit. The location is the address modulo `DEPTH`.
- R4: The mode byte is taken over the following 4 clocks in the same pair order. Its bits 3:0 have no effect. Bits 5:4 equal to 2'b10 arm continuous state.
- R5: With continuous state armed, the next select assertion starts directly with the 12 address clocks.
- R6: Any other value of mode bits 5:4 leaves the block in normal state for the next select assertion.
- R7: In continuous state, 16 clocks with `io_in[0]` high and `io_in[1]` low give mode bit 4 = 1 and return the block to normal state.
- R8: Output begins on the falling edge after the last mode clock. Each falling edge drives one pair, bit 7 on `io_out[1]` and bit 6 on `io_out[0]` first. The byte at location `a` is `(29*a + 0x47) mod 256`.
- R9: The read location advances by one after every 4 output clocks and wraps from `DEPTH-1` to 0.
- R10: `io_oe` is 2'b11 only in the output phase while select is low, and 2'b00 at all other times. Select rising restarts the clock count but keeps the continuous state.
- R11: After an instruction other than 0xBB, `io_oe` stays 2'b00 until select rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sclk | input | 1 | Serial clock; inputs sampled on rising edge, outputs updated on falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low select |
| io_in | input | 2 | Values seen on the two data lines |
| io_out | output | 2 | Values driven onto the two data lines |
| io_oe | output | 2 | Output enable per data line |

## Verification
The bench uses addresses with set high bits and starts near the top of the memory, so a responder that decodes too many address bits returns the wrong bytes. One that forgets to wrap returns bytes from the wrong end of the memory. It uses mode bytes of 0x2F, 0x30 and 0x00. A decoder that looks at the low nibble or at the wrong pair then either fails to arm continuous state or arms it wrongly, and the next transfer is misread as instruction or as address. It aborts a continuous transfer partway through the address and sends the sixteen-ones exit pattern. A design that clears the flag on select rise, or never clears it, then returns wrong data on the following read. An unsupported instruction is followed by clocks through where the output phase would fall, which exposes any enable that leaks outside a valid read.

// File: rtl/drr_pkg.sv
`timescale 1ns/1ps
package drr_pkg;
    typedef enum logic [2:0] {
        ST_CMD,
        ST_ADDR,
        ST_MODE,
        ST_DATA,
        ST_IGNORE
    } drr_state_e;

    localparam logic [7:0] DUAL_READ_OPCODE = 8'hBB;
    localparam logic [1:0] CONT_KEY         = 2'b10;
endpackage

// File: rtl/drr_rom.sv
`timescale 1ns/1ps
// Pattern memory: location a holds (29*a + 0x47) mod 256.
module drr_rom #(
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic [AW-1:0] index,
    output logic [7:0]    data
);
    logic [7:0] table_w [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_cell
        assign table_w[i] = 8'((i * 29 + 71) % 256);
    end

    assign data = table_w[index];
endmodule

// File: rtl/drr_tx.sv
`timescale 1ns/1ps
// Falling-edge pair serializer for the output phase.
module drr_tx (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       send,
    input  logic [7:0] byte_in,
    input  logic [1:0] pair_sel,
    output logic [1:0] pair_q,
    output logic [1:0] oe_q
);
    logic [1:0] pair_d;

    always_comb begin
        unique case (pair_sel)
            2'd0: pair_d = byte_in[7:6];
            2'd1: pair_d = byte_in[5:4];
            2'd2: pair_d = byte_in[3:2];
            2'd3: pair_d = byte_in[1:0];
            default: pair_d = 2'b00;
        endcase
    end

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pair_q <= 2'b00;
            oe_q   <= 2'b00;
        end else if (send) begin
            pair_q <= pair_d;
            oe_q   <= 2'b11;
        end else begin
            pair_q <= 2'b00;
            oe_q   <= 2'b00;
        end
    end
endmodule

// File: rtl/dual_read_responder.sv
`timescale 1ns/1ps
module dual_read_responder
    import drr_pkg::*;
#(
    parameter int DEPTH     = 64,
    parameter int ADDR_BITS = 24
) (
    input  logic       sclk,
    input  logic       rst_n,
    input  logic       cs_n,
    input  logic [1:0] io_in,
    output logic [1:0] io_out,
    output logic [1:0] io_oe
);
    localparam int AW        = $clog2(DEPTH);
    localparam int ADDR_CLKS = ADDR_BITS / 2;
    localparam int CNT_W     = $clog2(ADDR_CLKS);
    localparam logic [CNT_W-1:0] CMD_LAST  = CNT_W'(7);
    localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(ADDR_CLKS - 1);
    localparam logic [CNT_W-1:0] MODE_LAST = CNT_W'(3);

    drr_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic [6:0]       cmd_sh;
    logic [AW-1:0]    addr_sh;
    logic [3:0]       mode_sh;
    logic             cont_q;
    logic [AW-1:0]    rd_addr;
    logic [1:0]       pair_q;
    logic [7:0]       rd_byte;
    logic [1:0]       tx_pair, tx_oe;
    logic             mode_done;

    assign mode_done = !cs_n && (state_q == ST_MODE) && (cnt_q == MODE_LAST);

    // Next-state decision
    always_comb begin
        state_d = state_q;
        if (cs_n) begin
            state_d = cont_q ? ST_ADDR : ST_CMD;
        end else begin
            unique case (state_q)
                ST_CMD:
                    if (cnt_q == CMD_LAST)
                        state_d = ({cmd_sh, io_in[0]} == DUAL_READ_OPCODE) ? ST_ADDR : ST_IGNORE;
                ST_ADDR:
                    if (cnt_q == ADDR_LAST) state_d = ST_MODE;
                ST_MODE:
                    if (cnt_q == MODE_LAST) state_d = ST_DATA;
                ST_DATA:   state_d = ST_DATA;
                ST_IGNORE: state_d = ST_IGNORE;
                default:   state_d = ST_CMD;
            endcase
        end
    end

    // State register and phase clock counter
    always_ff @(posedge sclk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_CMD;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (cs_n || state_d != state_q)
                cnt_q <= '0;
            else if (state_q == ST_CMD || state_q == ST_ADDR || state_q == ST_MODE)
                cnt_q <= cnt_q + 1'b1;
        end
    end

    // Capture shifters, continuous flag and read pointer
    always_ff @(posedge sclk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_sh  <= '0;
            addr_sh <= '0;
            mode_sh <= '0;
            cont_q  <= 1'b0;
            rd_addr <= '0;
            pair_q  <= '0;
        end else if (!cs_n) begin
            unique case (state_q)
                ST_CMD:  cmd_sh  <= {cmd_sh[5:0], io_in[0]};
                ST_ADDR: addr_sh <= {addr_sh[AW-3:0], io_in[1], io_in[0]};
                ST_MODE: begin
                    mode_sh <= {mode_sh[1:0], io_in};
                    if (mode_done) begin
                        cont_q  <= (mode_sh[3:2] == CONT_KEY);
                        rd_addr <= addr_sh;
                        pair_q  <= 2'd0;
                    end
                end
                ST_DATA: begin
                    pair_q <= pair_q + 1'b1;
                    if (pair_q == 2'd3) rd_addr <= rd_addr + 1'b1;
                end
                ST_IGNORE: ;
                default: ;
            endcase
        end
    end

    drr_rom #(.DEPTH(DEPTH)) rom_i (
        .index (rd_addr),
        .data  (rd_byte)
    );

    drr_tx tx_i (
        .clk      (sclk),
        .rst_n    (rst_n),
        .send     ((state_q == ST_DATA) && !cs_n),
        .byte_in  (rd_byte),
        .pair_sel (pair_q),
        .pair_q   (tx_pair),
        .oe_q     (tx_oe)
    );

    // Output process
    always_comb begin
        io_out = tx_pair;
        io_oe  = tx_oe & {2{~cs_n}};
    end

    // R2: the 8th instruction clock always leaves instruction capture
    assert_cmd_len_R2: assert property (@(posedge sclk) disable iff (!rst_n)
        (!cs_n && state_q == ST_CMD && cnt_q == CMD_LAST) |=>
            (state_q == ST_ADDR || state_q == ST_IGNORE));

    // R4: continuous flag follows mode bits 5:4 at the end of the mode phase
    assert_mode_decode_R4: assert property (@(posedge sclk) disable iff (!rst_n)
        mode_done |=> (cont_q == ($past(mode_sh[3:2]) == CONT_KEY)));

    // R5: armed flag sends the next select straight to address capture
    assert_cont_entry_R5: assert property (@(posedge sclk) disable iff (!rst_n)
        (cs_n && cont_q) |=> (state_q == ST_ADDR));

    // R9: read pointer steps by one after each fourth output clock
    assert_addr_step_R9: assert property (@(posedge sclk) disable iff (!rst_n)
        (!cs_n && state_q == ST_DATA && pair_q == 2'd3) |=>
            (rd_addr == AW'($past(rd_addr) + 1'b1)));

    // R10/R11: serializer enable only follows the output phase
    assert_oe_data_only_R10: assert property (@(posedge sclk) disable iff (!rst_n)
        (state_q != ST_DATA) |-> (tx_oe == 2'b00));
endmodule

// File: tb/dual_read_responder_tb_top.sv
`timescale 1ns/1ps
module dual_read_responder_tb_top;
    localparam int DEPTH = 64;

    logic       sclk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1;
    logic [1:0] io_in = 2'b00;
    logic [1:0] io_out;
    logic [1:0] io_oe;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 sclk = ~sclk;

    dual_read_responder #(.DEPTH(DEPTH)) dut_i (
        .sclk   (sclk),
        .rst_n  (rst_n),
        .cs_n   (cs_n),
        .io_in  (io_in),
        .io_out (io_out),
        .io_oe  (io_oe)
    );

    function automatic logic [7:0] pattern(input int loc);
        return 8'(((loc % DEPTH) * 29 + 71) % 256);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One input clock: drive on falling edge, check enables stay off (R10)
    task automatic put_pair(input logic [1:0] v);
        @(negedge sclk);
        cs_n  = 1'b0;
        io_in = v;
        #1;
        check(io_oe == 2'b00, "R10 input-phase oe", io_oe, 0);
    endtask

    task automatic end_select();
        @(negedge sclk);
        cs_n  = 1'b1;
        io_in = 2'b00;
        repeat (2) @(negedge sclk);
        #1;
        check(io_oe == 2'b00, "R10 oe after select high", io_oe, 0);
    endtask

    // Full transfer; checks returned bytes when a read is expected
    task automatic xfer(input bit with_cmd, input logic [7:0] cmd, input logic [23:0] addr,
                        input logic [7:0] mode, input int nbytes, input bit expect_data,
                        input string tag);
        if (with_cmd)
            for (int i = 7; i >= 0; i--) put_pair({1'b0, cmd[i]});
        for (int i = 11; i >= 0; i--) put_pair({addr[2*i+1], addr[2*i]});
        for (int i = 3; i >= 0; i--) put_pair({mode[2*i+1], mode[2*i]});
        for (int b = 0; b < nbytes; b++) begin
            logic [7:0] got;
            logic [7:0] exp;
            got = 8'h00;
            exp = pattern(int'(addr % DEPTH) + b);
            for (int p = 0; p < 4; p++) begin
                @(negedge sclk);
                io_in = 2'b00;
                #1;
                got = {got[5:0], io_out};
                if (expect_data)
                    check(io_oe == 2'b11, {tag, " R10 data-phase oe"}, io_oe, 3);
                else
                    check(io_oe == 2'b00, {tag, " R11 ignored oe"}, io_oe, 0);
            end
            if (expect_data) check(got == exp, {tag, " R8 byte"}, got, exp);
        end
        end_select();
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge sclk);
        #1;
        check(io_oe == 2'b00, "R1 oe in reset", io_oe, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge sclk);
        #1;
        check(io_oe == 2'b00, "R1 oe after reset", io_oe, 0);
        xfer(1'b1, 8'hBB, 24'h000004, 8'h00, 1, 1'b1, "R1 first read");
    endtask

    task automatic t_basic();   // R2, R3, R8
        xfer(1'b1, 8'hBB, 24'h000010, 8'h00, 3, 1'b1, "R2 R3 basic");
        xfer(1'b1, 8'hBB, 24'hC3F005, 8'h00, 2, 1'b1, "R3 high bits");
    endtask

    task automatic t_wrap();    // R9
        xfer(1'b1, 8'hBB, 24'h00003E, 8'h00, 4, 1'b1, "R9 wrap");
    endtask

    task automatic t_other_mode(); // R6
        xfer(1'b1, 8'hBB, 24'h000020, 8'h30, 1, 1'b1, "R6 mode 30");
        xfer(1'b1, 8'hBB, 24'h000021, 8'h10, 1, 1'b1, "R6 after 30");
        xfer(1'b1, 8'hBB, 24'h000022, 8'h00, 1, 1'b1, "R6 after 10");
    endtask

    task automatic t_cont();    // R4, R5
        xfer(1'b1, 8'hBB, 24'h000007, 8'h2F, 1, 1'b1, "R4 arm with 2F");
        xfer(1'b0, 8'h00, 24'h000021, 8'h20, 2, 1'b1, "R5 no-instruction read");
    endtask

    task automatic t_abort();   // R10 flag survives select rise
        for (int i = 0; i < 6; i++) put_pair(2'b11);
        end_select();
        xfer(1'b0, 8'h00, 24'h00000A, 8'h20, 1, 1'b1, "R10 flag kept");
    endtask

    task automatic t_exit();    // R7
        for (int i = 0; i < 16; i++) put_pair(2'b01);
        end_select();
        xfer(1'b1, 8'hBB, 24'h000012, 8'h00, 2, 1'b1, "R7 normal after exit");
    endtask

    task automatic t_ignore();  // R11
        xfer(1'b1, 8'h03, 24'h000005, 8'h20, 2, 1'b0, "R11 other instruction");
        xfer(1'b1, 8'hBB, 24'h000030, 8'h00, 1, 1'b1, "R11 recovery read");
    endtask

    initial begin
        t_reset();
        t_basic();
        t_wrap();
        t_other_mode();
        t_cont();
        t_abort();
        t_exit();
        t_ignore();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #200us;
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule